// File: doc/BRIEF.md
# Write-Latched Cartridge Bank Controller

This block maps an 8 KB window of a 16-bit CPU's 64 KB address space onto a much larger external ROM. Software picks a bank by writing into the window itself rather than to a separate port. Such a write stores no data in ROM. Instead, the low address lines of that write and both bytes of the data bus are captured together as one wide bank number. The bank register then supplies the upper address bits of the external ROM. The low 13 CPU address bits pass straight through as the offset within the bank.

A split mode divides the window into two 4 KB halves. The lower half stays ROM. The upper half becomes a RAM page with its own bank register. In this mode, writes to the lower half load one of the two registers, and a single address bit picks which one. Writes to the upper half are real RAM writes and leave both registers alone.

The CPU side is a plain strobe bus. Each read or write strobe is complete in the cycle in which it is asserted. There is no back-pressure, so no valid/ready pair is needed. A new bank is visible from the cycle after the write that loads it.

Top module: `cbank_ctrl`

## Requirements
- R1: After reset both bank registers are zero, so a window read at 0x6000 drives rom_addr = 0 with rom_cs high.
- R2: An access with cpu_addr outside 0x6000–0x7FFF asserts neither chip select and changes no bank register.
- R3: In full mode (split_en = 0), a window write loads the ROM bank with {cpu_addr[11:0], cpu_wdata[15:8], cpu_wdata[7:0]}, a 28-bit value. rom_cs stays low during that write.
- R4: A read never changes either bank register, whatever is on the data bus.
- R5: During the loading write, rom_addr and ram_addr still carry the old bank. The new bank appears on the first access in the following cycle.
- R6: In full mode a window read drives rom_cs = 1, rom_addr = {rom_bank, cpu_addr[12:0]} and ram_cs = 0.
- R7: In split mode the ROM half is cpu_addr[12] = 0. A write there loads {1'b0, cpu_addr[10:0], cpu_wdata}. It loads the ROM bank when cpu_addr[11] = 0 and the RAM bank when cpu_addr[11] = 1. A read there drives rom_cs with rom_addr = {rom_bank, cpu_addr[12:0]}.
- R8: In split mode the RAM half is cpu_addr[12] = 1. Any access there drives ram_cs = 1, ram_we = cpu_wr and ram_addr = {ram_bank, cpu_addr[11:0]}, keeps rom_cs low and changes no bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_en | input | 1 | 1 selects the split ROM/RAM window |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 16 | CPU write data bus |
| cpu_rd | input | 1 | Read strobe, one access per cycle |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| rom_cs | output | 1 | External ROM select (window reads only) |
| rom_addr | output | 41 | External ROM address: bank then 13-bit offset |
| ram_cs | output | 1 | External RAM select (split mode, upper half) |
| ram_we | output | 1 | External RAM write enable |
| ram_addr | output | 40 | External RAM address: RAM bank then 12-bit offset |

## Verification
The bench targets the one-cycle boundary of a bank change. A design that bypasses the register would show the new bank during the loading write itself. A design that adds an extra stage would still show the old bank on the next read. The bench drives reads with all-ones data and writes just outside the window edges at 0x5FFF and 0x8000; a decode that ignores the strobe type or is one address bit short would corrupt the bank there. In split mode it aims writes at both halves and both values of the select bit. This catches a RAM-half write that loads a bank, a swapped register select, and a missing zero in the top bank bit.

// File: rtl/cbank_pkg.sv
package cbank_pkg;

  localparam int NUM_BANK_REGS = 2;
  localparam int REG_ROM       = 0;
  localparam int REG_RAM       = 1;

  typedef struct packed {
    logic hit;       // access inside the window
    logic ram_half;  // split mode, upper half
    logic ld_rom;    // load ROM bank register
    logic ld_ram;    // load RAM bank register
    logic rom_sel;   // drive ROM chip select
    logic ram_sel;   // drive RAM chip select
  } dec_t;

endpackage

// File: rtl/cbank_decode.sv
module cbank_decode
  import cbank_pkg::*;
#(
  parameter int WIN_BITS = 3,
  parameter logic [WIN_BITS-1:0] WIN_TAG = 3'b011
) (
  input  logic [WIN_BITS-1:0] win_bits,
  input  logic                half_bit,
  input  logic                sel_bit,
  input  logic                rd,
  input  logic                wr,
  input  logic                split_en,
  output dec_t                dec
);

  logic in_win;
  logic upper;

  always_comb begin
    in_win = (win_bits == WIN_TAG);
    upper  = split_en && half_bit;

    dec          = '0;
    dec.hit      = in_win && (rd || wr);
    dec.ram_half = upper;
    dec.ram_sel  = dec.hit && upper;
    dec.rom_sel  = dec.hit && !wr && !upper;
    dec.ld_rom   = dec.hit && wr && !upper && (!split_en || !sel_bit);
    dec.ld_ram   = dec.hit && wr && split_en && !half_bit && sel_bit;
  end

endmodule

// File: rtl/cbank_latch.sv
module cbank_latch
  import cbank_pkg::*;
#(
  parameter int ABANK_W = 12,
  parameter int DATA_W  = 16,
  localparam int BANK_W = ABANK_W + DATA_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  split_en,
  input  logic [ABANK_W-1:0]                    addr_lo,
  input  logic [DATA_W-1:0]                     wdata,
  input  logic [NUM_BANK_REGS-1:0]              load,
  output logic [NUM_BANK_REGS-1:0][BANK_W-1:0]  bank_q
);

  logic [BANK_W-1:0] next_val;

  always_comb begin
    if (split_en) next_val = {1'b0, addr_lo[ABANK_W-2:0], wdata};
    else          next_val = {addr_lo, wdata};
  end

  for (genvar g = 0; g < NUM_BANK_REGS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q[g] <= '0;
      else if (load[g]) bank_q[g] <= next_val;
    end
  end

endmodule

// File: rtl/cbank_map.sv
module cbank_map #(
  parameter int BANK_W = 28,
  parameter int OFFS_W = 13,
  localparam int HALF_W = OFFS_W - 1
) (
  input  logic [BANK_W-1:0]        rom_bank,
  input  logic [BANK_W-1:0]        ram_bank,
  input  logic [OFFS_W-1:0]        offset,
  output logic [BANK_W+OFFS_W-1:0] rom_addr,
  output logic [BANK_W+HALF_W-1:0] ram_addr
);

  assign rom_addr = {rom_bank, offset};
  assign ram_addr = {ram_bank, offset[HALF_W-1:0]};

endmodule

// File: rtl/cbank_ctrl.sv
module cbank_ctrl
  import cbank_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int WIN_BITS = 3,
  parameter logic [WIN_BITS-1:0] WIN_TAG = 3'b011,
  parameter int ABANK_W  = 12,
  localparam int OFFS_W  = ADDR_W - WIN_BITS,
  localparam int HALF_W  = OFFS_W - 1,
  localparam int BANK_W  = ABANK_W + DATA_W,
  localparam int ROM_AW  = BANK_W + OFFS_W,
  localparam int RAM_AW  = BANK_W + HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr
);

  dec_t                                 dec;
  logic [NUM_BANK_REGS-1:0]             load;
  logic [NUM_BANK_REGS-1:0][BANK_W-1:0] bank_q;

  cbank_decode #(.WIN_BITS(WIN_BITS), .WIN_TAG(WIN_TAG)) u_dec (
    .win_bits (cpu_addr[ADDR_W-1 -: WIN_BITS]),
    .half_bit (cpu_addr[OFFS_W-1]),
    .sel_bit  (cpu_addr[ABANK_W-1]),
    .rd       (cpu_rd),
    .wr       (cpu_wr),
    .split_en (split_en),
    .dec      (dec)
  );

  always_comb begin
    load          = '0;
    load[REG_ROM] = dec.ld_rom;
    load[REG_RAM] = dec.ld_ram;
  end

  cbank_latch #(.ABANK_W(ABANK_W), .DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .split_en (split_en),
    .addr_lo  (cpu_addr[ABANK_W-1:0]),
    .wdata    (cpu_wdata),
    .load     (load),
    .bank_q   (bank_q)
  );

  cbank_map #(.BANK_W(BANK_W), .OFFS_W(OFFS_W)) u_map (
    .rom_bank (bank_q[REG_ROM]),
    .ram_bank (bank_q[REG_RAM]),
    .offset   (cpu_addr[OFFS_W-1:0]),
    .rom_addr (rom_addr),
    .ram_addr (ram_addr)
  );

  assign rom_cs = dec.rom_sel;
  assign ram_cs = dec.ram_sel;
  assign ram_we = dec.ram_sel && cpu_wr;

endmodule

// File: rtl/cbank_ctrl_chk.sv
module cbank_ctrl_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int WIN_BITS = 3,
  parameter logic [WIN_BITS-1:0] WIN_TAG = 3'b011,
  parameter int ABANK_W  = 12,
  localparam int OFFS_W  = ADDR_W - WIN_BITS,
  localparam int HALF_W  = OFFS_W - 1,
  localparam int BANK_W  = ABANK_W + DATA_W,
  localparam int ROM_AW  = BANK_W + OFFS_W,
  localparam int RAM_AW  = BANK_W + HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              split_en,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              rom_cs,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              ram_cs,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr
);

  logic win;
  assign win = (cpu_addr[ADDR_W-1 -: WIN_BITS] == WIN_TAG);

  AST_OUTSIDE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> (!rom_cs && !ram_cs)); // R2

  AST_OUTSIDE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !win |=> ($stable(rom_addr[ROM_AW-1:OFFS_W]) && $stable(ram_addr[RAM_AW-1:HALF_W]))); // R2

  AST_FULL_WR_NO_ROM_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !split_en) |-> !rom_cs); // R3

  AST_FULL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && win && !split_en) |=>
      (rom_addr[ROM_AW-1:OFFS_W] == $past({cpu_addr[ABANK_W-1:0], cpu_wdata}))); // R3

  AST_READ_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr) |=> ($stable(rom_addr[ROM_AW-1:OFFS_W]) && $stable(ram_addr[RAM_AW-1:HALF_W]))); // R4

  AST_ROM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> (rom_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0])); // R6

  AST_SPLIT_RAM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && win && split_en && !cpu_addr[OFFS_W-1] && cpu_addr[ABANK_W-1]) |=>
      (ram_addr[RAM_AW-1:HALF_W] == $past({1'b0, cpu_addr[ABANK_W-2:0], cpu_wdata}))); // R7

  AST_RAM_ONLY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> (split_en && !rom_cs && ram_addr[HALF_W-1:0] == cpu_addr[HALF_W-1:0])); // R8

  AST_RAM_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_cs); // R8

endmodule

bind cbank_ctrl cbank_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .WIN_TAG(WIN_TAG), .ABANK_W(ABANK_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .split_en(split_en), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs),
  .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/cbank_ctrl_tb_top.sv
module cbank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        split_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        rom_cs, ram_cs, ram_we;
  logic [40:0] rom_addr;
  logic [39:0] ram_addr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [27:0] m_rom = '0;
  logic [27:0] m_ram = '0;

  always #4 clk = ~clk;

  cbank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .split_en(split_en), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs),
    .ram_we(ram_we), .ram_addr(ram_addr)
  );

  function automatic bit in_win(logic [15:0] a);
    return a >= 16'h6000 && a <= 16'h7FFF;
  endfunction

  // reference model state update, behavioural
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rom = '0;
      m_ram = '0;
    end else if (cpu_wr && in_win(cpu_addr) && !(split_en && cpu_addr[12])) begin
      if (!split_en)          m_rom = {cpu_addr[11:0], cpu_wdata};
      else if (cpu_addr[11])  m_ram = {1'b0, cpu_addr[10:0], cpu_wdata};
      else                    m_rom = {1'b0, cpu_addr[10:0], cpu_wdata};
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit hit, upper, e_rom_cs, e_ram_cs, e_ram_we;
      logic [40:0] e_rom_addr;
      logic [39:0] e_ram_addr;
      string tag;
      hit        = in_win(cpu_addr) && (cpu_rd || cpu_wr);
      upper      = split_en && cpu_addr[12];
      e_rom_cs   = hit && !cpu_wr && !upper;
      e_ram_cs   = hit && upper;
      e_ram_we   = e_ram_cs && cpu_wr;
      e_rom_addr = {m_rom, cpu_addr[12:0]};
      e_ram_addr = {m_ram, cpu_addr[11:0]};
      if (!in_win(cpu_addr))  tag = "R2";
      else if (upper)         tag = "R8";
      else if (split_en)      tag = "R7";
      else if (cpu_wr)        tag = "R3";
      else                    tag = "R6";
      total++;
      if (rom_cs !== e_rom_cs || ram_cs !== e_ram_cs || ram_we !== e_ram_we ||
          rom_addr !== e_rom_addr || ram_addr !== e_ram_addr) begin
        bad++;
        $display("FAIL %s cyc=%0d act rom_cs=%b rom_addr=%h ram_cs=%b ram_we=%b ram_addr=%h exp %b %h %b %b %h",
                 tag, cycles, rom_cs, rom_addr, ram_cs, ram_we, ram_addr,
                 e_rom_cs, e_rom_addr, e_ram_cs, e_ram_we, e_ram_addr);
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(bit wr, logic [15:0] a, logic [15:0] d);
    @(posedge clk);
    #2;
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_wr    = wr;
    cpu_rd    = !wr;
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    @(posedge clk);
    #2;
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    acc(1'b0, 16'h6000, 16'hFFFF);
    chk("R1", {63'd0, rom_cs}, 64'd1);
    chk("R1", {23'd0, rom_addr}, 64'd0);

    // R3 / R5: full-mode latch, old bank during the write
    acc(1'b1, 16'h6ABC, 16'h1234);
    chk("R3", {63'd0, rom_cs}, 64'd0);
    chk("R5", {23'd0, rom_addr[40:13]}, 64'd0);
    acc(1'b0, 16'h7001, 16'h0000);
    chk("R5", {23'd0, rom_addr}, {23'd0, 28'hABC1234, 13'h1001});
    chk("R6", {63'd0, rom_cs}, 64'd1);

    // R4: read with busy data bus leaves bank
    acc(1'b0, 16'h6555, 16'hFFFF);
    acc(1'b0, 16'h6000, 16'h0000);
    chk("R4", {23'd0, rom_addr[40:13]}, {36'd0, 28'hABC1234});

    // R2: writes just outside the window
    acc(1'b1, 16'h5FFF, 16'h5555);
    chk("R2", {62'd0, rom_cs, ram_cs}, 64'd0);
    acc(1'b1, 16'h8000, 16'hAAAA);
    acc(1'b0, 16'h6000, 16'h0000);
    chk("R2", {23'd0, rom_addr[40:13]}, {36'd0, 28'hABC1234});

    // R7: split-mode loads of both registers
    split_en = 1'b1;
    acc(1'b1, 16'h6123, 16'hBEEF);
    acc(1'b1, 16'h6923, 16'h0042);
    acc(1'b0, 16'h6010, 16'h0000);
    chk("R7", {23'd0, rom_addr}, {23'd0, 1'b0, 11'h123, 16'hBEEF, 13'h0010});
    chk("R7", {24'd0, ram_addr[39:12], 12'd0}, {24'd0, 1'b0, 11'h123, 16'h0042, 12'd0});

    // R8: RAM-half write is a RAM write only
    acc(1'b1, 16'h7456, 16'h9999);
    chk("R8", {61'd0, rom_cs, ram_cs, ram_we}, 64'd3);
    chk("R8", {24'd0, ram_addr}, {24'd0, 1'b0, 11'h123, 16'h0042, 12'h456});
    acc(1'b0, 16'h6000, 16'h0000);
    chk("R8", {23'd0, rom_addr[40:13]}, {36'd0, 1'b0, 11'h123, 16'hBEEF});

    // back to full mode: whole window is ROM again
    split_en = 1'b0;
    acc(1'b0, 16'h7FFF, 16'h0000);
    chk("R6", {63'd0, rom_cs}, 64'd1);

    // mixed traffic, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      int r;
      r = int'($urandom_range(0, 9));
      a = 16'($urandom);
      if (r < 8) a[15:13] = 3'b011;
      if (i % 400 == 0) split_en = ~split_en;
      if (r == 9) idle();
      else acc($urandom_range(0, 3) == 0, a, 16'($urandom));
    end
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule